// File: doc/BRIEF.md
# Video Interrupt Request Generator

This block is the interrupt source of a video display controller. Two timing events come in as one-cycle pulses: one marks the end of a scan line and one marks the start of vertical blanking. Each pulse latches a pending flag. When a flag's enable bit is set, the flag is presented to the CPU on two active-low priority lines. The line interrupt uses level 4 and the frame interrupt uses level 6. While any level is shown, the block also drives an active-low autovector request, so the CPU creates the vector itself and does not read one from the bus.

The CPU acknowledges through an active-low strobe. The block detects the falling edge of that strobe and clears one pending flag. It picks the flag that is highest and enabled at that instant, not the one the CPU actually accepted. This choice reproduces a known hazard on purpose. A frame event can land after the CPU has committed to servicing the line interrupt but before it acknowledges. The acknowledge then clears the frame flag, the frame interrupt is lost, and the line interrupt is presented again and serviced a second time.

Top module: `vid_irq_gen`

## Requirements
- R1: While reset is held and right after it is released, no flag is pending: `iplN` is 2'b11 and `vpaN` is 1.
- R2: A line event pulse with `hEnable` high presents level 4 (binary 100). The lines carry level bits 2 and 1 inverted, so `iplN` = 2'b01.
- R3: A frame event pulse with `vEnable` high presents level 6 (binary 110), so `iplN` = 2'b00.
- R4: When both flags are pending and both are enabled, `iplN` shows level 6. It drops to level 4 only after the frame flag has been cleared.
- R5: Pending flags do not depend on the enable bits. An event taken while its enable is low is presented as soon as the enable is raised.
- R6: `vpaN` is low exactly when `iplN` shows a nonzero level.
- R7: Each falling edge of `ackN` clears exactly one flag: the highest one that is both pending and enabled. Holding `ackN` low for more cycles clears nothing further.
- R8: An acknowledge edge that finds no flag both pending and enabled clears nothing. A disabled pending flag survives it.
- R9: Suppose the line interrupt is shown and a frame event arrives before the acknowledge edge. The acknowledge then clears the frame flag, and level 4 is shown again.
- R10: An event pulse in the same cycle as an acknowledge that clears that same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hEvent | input | 1 | Line event pulse, one cycle |
| vEvent | input | 1 | Frame event pulse, one cycle |
| hEnable | input | 1 | Enable for the line interrupt |
| vEnable | input | 1 | Enable for the frame interrupt |
| ackN | input | 1 | CPU acknowledge strobe, active low, edge-detected |
| iplN | output | 2 | Priority level bits 2:1, active low |
| vpaN | output | 1 | Autovector request, active low |

## Verification
Two functions can fall in the same clock edge: setting a flag from an event pulse, and clearing a flag on an acknowledge edge. The bench provokes this in two ways. First, it raises the frame event one cycle before the acknowledge edge while level 4 is shown; here the expected result is that the frame flag is cleared and level 4 returns. Second, it pulses the frame event in the very cycle of the acknowledge edge that targets the frame flag; here the set must win and level 6 must stay. Every expected level comes from a flag model in the bench that is driven by the same stimulus, and it is compared one nanosecond after the edge.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;

  // Strobes from control to datapath, at most one high per cycle.
  typedef struct packed {
    logic clrH;
    logic clrV;
  } irqStrobe_t;

  // Tracks whether the acknowledge strobe is currently held.
  typedef enum logic {
    ACK_IDLE = 1'b0,
    ACK_HELD = 1'b1
  } ackState_t;

endpackage

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackN,
  input  logic       hPend,
  input  logic       vPend,
  input  logic       hEnable,
  input  logic       vEnable,
  output irqStrobe_t strobe
);

  ackState_t ackState;
  logic      ackFall;
  logic      vLive;
  logic      hLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackState <= ACK_IDLE;
    end else begin
      ackState <= ackN ? ACK_IDLE : ACK_HELD;
    end
  end

  // First cycle in which the strobe is seen low.
  assign ackFall = (ackState == ACK_IDLE) && !ackN;

  assign vLive = vPend && vEnable;
  assign hLive = hPend && hEnable;

  // The flag to clear is chosen from what is highest right now,
  // not from what the CPU accepted earlier.
  always_comb begin
    strobe      = '0;
    strobe.clrV = ackFall && vLive;
    strobe.clrH = ackFall && hLive && !vLive;
  end

endmodule

// File: rtl/vid_irq_dp.sv
module vid_irq_dp
  import vid_irq_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int H_LEVEL  = 4,
  parameter int V_LEVEL  = 6,
  parameter int LINE_LSB = 1,
  parameter int LINE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hEvent,
  input  logic              vEvent,
  input  logic              hEnable,
  input  logic              vEnable,
  input  irqStrobe_t        strobe,
  output logic              hPend,
  output logic              vPend,
  output logic [LINE_W-1:0] iplN,
  output logic              vpaN
);

  logic [LVL_W-1:0] level;

  // An event pulse takes precedence over a clear of the same flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPend <= 1'b0;
      vPend <= 1'b0;
    end else begin
      if (hEvent)           hPend <= 1'b1;
      else if (strobe.clrH) hPend <= 1'b0;
      if (vEvent)           vPend <= 1'b1;
      else if (strobe.clrV) vPend <= 1'b0;
    end
  end

  always_comb begin
    if (vPend && vEnable)      level = LVL_W'(V_LEVEL);
    else if (hPend && hEnable) level = LVL_W'(H_LEVEL);
    else                       level = '0;
  end

  for (genvar i = 0; i < LINE_W; i++) begin : g_line
    assign iplN[i] = ~level[LINE_LSB + i];
  end

  assign vpaN = ~(|level);

endmodule

// File: rtl/vid_irq_gen.sv
module vid_irq_gen
  import vid_irq_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int H_LEVEL  = 4,
  parameter int V_LEVEL  = 6,
  parameter int LINE_LSB = 1,
  parameter int LINE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hEvent,
  input  logic              vEvent,
  input  logic              hEnable,
  input  logic              vEnable,
  input  logic              ackN,
  output logic [LINE_W-1:0] iplN,
  output logic              vpaN
);

  irqStrobe_t strobe;
  logic       hPend;
  logic       vPend;

  vid_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ackN    (ackN),
    .hPend   (hPend),
    .vPend   (vPend),
    .hEnable (hEnable),
    .vEnable (vEnable),
    .strobe  (strobe)
  );

  vid_irq_dp #(
    .LVL_W    (LVL_W),
    .H_LEVEL  (H_LEVEL),
    .V_LEVEL  (V_LEVEL),
    .LINE_LSB (LINE_LSB),
    .LINE_W   (LINE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .hEvent  (hEvent),
    .vEvent  (vEvent),
    .hEnable (hEnable),
    .vEnable (vEnable),
    .strobe  (strobe),
    .hPend   (hPend),
    .vPend   (vPend),
    .iplN    (iplN),
    .vpaN    (vpaN)
  );

endmodule

// File: rtl/vid_irq_chk.sv
module vid_irq_chk #(
  parameter int LINE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              hEvent,
  input logic              vEvent,
  input logic              hEnable,
  input logic              vEnable,
  input logic              ackN,
  input logic [LINE_W-1:0] iplN,
  input logic              vpaN
);

  logic ackPrevChk;
  logic fallChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPrevChk <= 1'b1;
    else       ackPrevChk <= ackN;
  end

  assign fallChk = ackPrevChk && !ackN;

  // R6: the autovector request goes with a nonzero level
  a_r6_vpa_with_level: assert property (@(posedge clk) disable iff (!rstN)
    vpaN == (iplN == '1));

  // R2: a level-4 code never shows up in an impossible form
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    iplN != 2'b10);

  // R3, R10: an enabled frame event is shown on the next cycle
  a_r3_v_shown: assert property (@(posedge clk) disable iff (!rstN)
    (vEvent && vEnable) |=> (!vEnable || iplN == 2'b00));

  // R2: an enabled line event always raises some level
  a_r2_h_shown: assert property (@(posedge clk) disable iff (!rstN)
    (hEvent && hEnable) |=> (!hEnable || iplN != 2'b11));

  // R7: level 6 can only go away on an acknowledge edge
  a_r7_v_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($past(iplN) == 2'b00 && $past(vEnable) && vEnable && !$past(fallChk))
      |-> iplN == 2'b00);

endmodule

bind vid_irq_gen vid_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hEvent  (hEvent),
  .vEvent  (vEvent),
  .hEnable (hEnable),
  .vEnable (vEnable),
  .ackN    (ackN),
  .iplN    (iplN),
  .vpaN    (vpaN)
);

// File: tb/tb_vid_irq_gen.sv
`timescale 1ns/1ps
module tb_vid_irq_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hEvent = 1'b0, vEvent = 1'b0;
  logic       hEnable = 1'b0, vEnable = 1'b0;
  logic       ackN = 1'b1;
  logic [1:0] iplN;
  logic       vpaN;

  typedef struct {
    logic [1:0] ipl;
    logic       vpa;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int   vecCnt = 0;
  int   errCnt = 0;
  bit   done = 1'b0;
  logic mH = 1'b0, mV = 1'b0, mPrevAck = 1'b1;

  always #2 clk = ~clk;

  vid_irq_gen dut (
    .clk(clk), .rstN(rstN), .hEvent(hEvent), .vEvent(vEvent),
    .hEnable(hEnable), .vEnable(vEnable), .ackN(ackN),
    .iplN(iplN), .vpaN(vpaN)
  );

  // Driver: apply one cycle of stimulus, update the flag model, queue the expectation.
  task automatic step(input logic rst, input logic h, input logic v,
                      input logic he, input logic ve, input logic ack,
                      input string tag);
    expItem_t it;
    logic fall, clrH, clrV;
    @(negedge clk);
    rstN = rst; hEvent = h; vEvent = v; hEnable = he; vEnable = ve; ackN = ack;
    @(posedge clk);
    if (!rst) begin
      mH = 1'b0; mV = 1'b0; mPrevAck = 1'b1;
    end else begin
      fall = mPrevAck && !ack;
      clrV = fall && mV && ve;
      clrH = fall && mH && he && !(mV && ve);
      if (h) mH = 1'b1; else if (clrH) mH = 1'b0;
      if (v) mV = 1'b1; else if (clrV) mV = 1'b0;
      mPrevAck = ack;
    end
    if (mV && ve)      it.ipl = 2'b00;
    else if (mH && he) it.ipl = 2'b01;
    else               it.ipl = 2'b11;
    it.vpa = (it.ipl == 2'b11);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      vecCnt++;
      if (iplN !== it.ipl || vpaN !== it.vpa) begin
        errCnt++;
        $display("FAIL %s: actual iplN=%b vpaN=%b expected iplN=%b vpaN=%b",
                 it.tag, iplN, vpaN, it.ipl, it.vpa);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, "R1");
    step(1, 0, 0, 1, 1, 1, "R1");
    // R2: line interrupt at level 4
    step(1, 1, 0, 1, 0, 1, "R2");
    step(1, 0, 0, 1, 0, 1, "R6");
    // R7: one edge clears, holding low adds nothing
    step(1, 0, 0, 1, 0, 0, "R7");
    step(1, 0, 0, 1, 0, 0, "R7");
    step(1, 0, 0, 1, 0, 1, "R7");
    // R3: frame interrupt at level 6
    step(1, 0, 1, 0, 1, 1, "R3");
    step(1, 0, 0, 0, 1, 0, "R3");
    step(1, 0, 0, 0, 1, 1, "R3");
    // R4: both pending, level 6 first
    step(1, 1, 0, 1, 1, 1, "R4");
    step(1, 0, 1, 1, 1, 1, "R4");
    step(1, 0, 0, 1, 1, 0, "R4");
    step(1, 0, 0, 1, 1, 0, "R7");
    step(1, 0, 0, 1, 1, 0, "R7");
    step(1, 0, 0, 1, 1, 1, "R4");
    step(1, 0, 0, 1, 1, 0, "R4");
    step(1, 0, 0, 1, 1, 1, "R6");
    // R5: late enable still delivers
    step(1, 1, 0, 0, 0, 1, "R5");
    step(1, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 0, 1, 0, 1, "R5");
    step(1, 0, 0, 1, 0, 0, "R5");
    step(1, 0, 0, 1, 0, 1, "R5");
    // R8: acknowledge with nothing enabled clears nothing
    step(1, 0, 1, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 1, 1, "R8");
    step(1, 0, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 0, 1, 1, "R8");
    // R9: frame event lands after level 4 is taken, before the acknowledge
    step(1, 1, 0, 1, 1, 1, "R9");
    step(1, 0, 1, 1, 1, 1, "R9");
    step(1, 0, 0, 1, 1, 0, "R9");
    step(1, 0, 0, 1, 1, 1, "R9");
    step(1, 0, 0, 1, 1, 0, "R9");
    step(1, 0, 0, 1, 1, 1, "R9");
    // R10: event in the same cycle as its own clear
    step(1, 0, 1, 0, 1, 1, "R10");
    step(1, 0, 1, 0, 1, 0, "R10");
    step(1, 0, 0, 0, 1, 1, "R10");
    step(1, 0, 0, 0, 1, 0, "R10");
    step(1, 0, 0, 0, 1, 1, "R10");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule